// File: doc/BRIEF.md
# Radix-2 Butterfly with One Shared Complex Multiplier

This block performs one complex radix-2 butterfly per clock on fixed-point data. Every cycle it can accept a top sample x, a bottom sample y and a twiddle exponent k. Three cycles later it presents a sum result and a difference result. A per-sample order bit selects time-decimated or frequency-decimated ordering.

In time-decimated order, the bottom sample is rotated by the twiddle before the add and subtract. In frequency-decimated order, the add and subtract come first, and only the difference is rotated. Either way, the datapath holds a single complex multiplier (four real products and two real adds) and two complex adders.

Twiddles are read from a table of N/2 complex Q1.15 constants that is built when the design is elaborated. The block never computes a sine or cosine at run time. The exponents k+N/2 are the negatives of the exponents k, so they have no entries of their own. A caller that needs such an exponent passes k and takes the difference output in place of the sum output.

A per-sample scale bit halves both results, with rounding, before they are clamped to the output range. This lets a multi-stage transform control its growth. Sequencing a whole transform, addressing its memory and reordering its bits belong to the surrounding logic.

The block has no control states. It is a straight three-register pipeline:
- Stage one registers the sample, the order, the scale bit and the twiddle. In frequency-decimated order it also forms the pre-sum and pre-difference.
- Stage two registers the complex product.
- Stage three applies rounding, the post add and subtract, scaling and saturation.

Top module: `bfly_r2`

## Requirements
- R1: While rst_n is low, and after reset until the first result, out_valid is 0 and all four output words are 0.
- R2: out_valid is 1 exactly 3 clock cycles after a cycle with in_valid 1, and 0 three cycles after a cycle with in_valid 0.
- R3: With in_order 0 (time-decimated), the results are sum = x + W·y and diff = x − W·y. Each real part of the product is (p + 2^14) >>> 15, where p is the exact integer sum of products with the Q1.15 twiddle.
- R4: With in_order 1 (frequency-decimated), the results are sum = x + y and diff = (x − y)·W, with the same product rounding as R3.
- R5: For k in 0..N/2−1, W has real part round(32767·cos(2πk/N)) and imaginary part round(−32767·sin(2πk/N)), rounding half away from zero. N defaults to 64.
- R6: With in_scale 1, each result component v becomes (v + 1) >>> 1 before saturation. With in_scale 0, it passes unchanged.
- R7: A result component above 32767 is output as 32767, and one below −32768 is output as −32768.
- R8: The order, scale and k of each sample are captured with its data, so samples with different settings may follow each other on consecutive cycles.
- R9: In a cycle where out_valid is 0, the four output words hold the values of the last valid result (0 if there has been none).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | The sample on the inputs is to be processed |
| in_order | input | 1 | 0 = rotate then add/subtract, 1 = add/subtract then rotate the difference |
| in_scale | input | 1 | 1 = halve both results with rounding |
| in_k | input | log2(N)−1 | Twiddle exponent, 0..N/2−1 |
| in_x_re | input | 16 | Top sample, real part, signed |
| in_x_im | input | 16 | Top sample, imaginary part, signed |
| in_y_re | input | 16 | Bottom sample, real part, signed |
| in_y_im | input | 16 | Bottom sample, imaginary part, signed |
| out_valid | output | 1 | Result words below are new this cycle |
| out_sum_re | output | 16 | Sum result, real part |
| out_sum_im | output | 16 | Sum result, imaginary part |
| out_dif_re | output | 16 | Difference result, real part |
| out_dif_im | output | 16 | Difference result, imaginary part |

## Verification
Each result is due three rising edges after the edge that captures its sample, with the same delay in both orders. The bench drives a sample on a falling edge and predicts its result with integer arithmetic. It places that prediction in a queue that is kept exactly three entries deep, and on every falling edge it compares the oldest entry with the outputs. On cycles that carry no result, the same comparison confirms that out_valid is low and that the words still hold the last result. Twiddle sweeps, back-to-back changes of order and scale, and full-scale operands are fed through this same queue, so rounding and clamping are checked in the cycle where they appear.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

    // Sample width and twiddle width defaults (two's complement, Q1.15 twiddle)
    localparam int DATA_W_DEF = 16;
    localparam int TWID_W_DEF = 16;
    localparam int NPOINT_DEF = 64;

    // Butterfly ordering carried along with each sample
    typedef enum logic {
        ORDER_ROT_FIRST = 1'b0,   // time-decimated: rotate y, then add/sub
        ORDER_ROT_LAST  = 1'b1    // frequency-decimated: add/sub, then rotate diff
    } order_e;

endpackage

// File: rtl/bfly_twiddle_rom.sv
module bfly_twiddle_rom #(
    parameter int NPT = bfly_pkg::NPOINT_DEF,
    parameter int TW  = bfly_pkg::TWID_W_DEF,
    parameter int KW  = $clog2(NPT) - 1
) (
    input  logic [KW-1:0]        k,
    output logic signed [TW-1:0] w_re,
    output logic signed [TW-1:0] w_im
);
    localparam int  HALF  = NPT / 2;
    localparam real PI    = 3.14159265358979323846;
    localparam real FULLS = real'((2 ** (TW - 1)) - 1);

    function automatic int round_away(input real v);
        if (v >= 0.0)
            return $rtoi(v + 0.5);
        else
            return $rtoi(v - 0.5);
    endfunction

    logic signed [TW-1:0] tab_re [HALF];
    logic signed [TW-1:0] tab_im [HALF];

    // One constant pair per exponent, fixed at elaboration
    for (genvar g = 0; g < HALF; g++) begin : g_entry
        localparam real ANG   = 2.0 * PI * real'(g) / real'(NPT);
        localparam int  ENT_R = round_away($cos(ANG) * FULLS);
        localparam int  ENT_I = round_away(-$sin(ANG) * FULLS);
        assign tab_re[g] = TW'(ENT_R);
        assign tab_im[g] = TW'(ENT_I);
    end

    assign w_re = tab_re[k];
    assign w_im = tab_im[k];

endmodule

// File: rtl/bfly_pre.sv
module bfly_pre #(
    parameter int DW = bfly_pkg::DATA_W_DEF,
    parameter int TW = bfly_pkg::TWID_W_DEF,
    parameter int KW = 5,
    parameter int OW = DW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_order,
    input  logic                 in_scale,
    input  logic [KW-1:0]        in_k,
    input  logic signed [DW-1:0] x_re,
    input  logic signed [DW-1:0] x_im,
    input  logic signed [DW-1:0] y_re,
    input  logic signed [DW-1:0] y_im,
    input  logic signed [TW-1:0] w_re,
    input  logic signed [TW-1:0] w_im,
    output logic                 s1_valid,
    output bfly_pkg::order_e     s1_order,
    output logic                 s1_scale,
    output logic signed [OW-1:0] s1_pass_re,
    output logic signed [OW-1:0] s1_pass_im,
    output logic signed [OW-1:0] s1_op_re,
    output logic signed [OW-1:0] s1_op_im,
    output logic signed [TW-1:0] s1_w_re,
    output logic signed [TW-1:0] s1_w_im
);
    import bfly_pkg::*;

    order_e               ord;
    logic signed [OW-1:0] xe_re, xe_im, ye_re, ye_im;
    logic signed [OW-1:0] nx_pass_re, nx_pass_im, nx_op_re, nx_op_im;

    assign ord   = order_e'(in_order);
    assign xe_re = OW'(x_re);
    assign xe_im = OW'(x_im);
    assign ye_re = OW'(y_re);
    assign ye_im = OW'(y_im);

    // Pass path feeds the post adder; operand path feeds the multiplier
    always_comb begin
        unique case (ord)
            ORDER_ROT_LAST: begin
                nx_pass_re = xe_re + ye_re;
                nx_pass_im = xe_im + ye_im;
                nx_op_re   = xe_re - ye_re;
                nx_op_im   = xe_im - ye_im;
            end
            default: begin
                nx_pass_re = xe_re;
                nx_pass_im = xe_im;
                nx_op_re   = ye_re;
                nx_op_im   = ye_im;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid   <= 1'b0;
            s1_order   <= ORDER_ROT_FIRST;
            s1_scale   <= 1'b0;
            s1_pass_re <= '0;
            s1_pass_im <= '0;
            s1_op_re   <= '0;
            s1_op_im   <= '0;
            s1_w_re    <= '0;
            s1_w_im    <= '0;
        end else begin
            s1_valid   <= in_valid;
            s1_order   <= ord;
            s1_scale   <= in_scale;
            s1_pass_re <= nx_pass_re;
            s1_pass_im <= nx_pass_im;
            s1_op_re   <= nx_op_re;
            s1_op_im   <= nx_op_im;
            s1_w_re    <= w_re;
            s1_w_im    <= w_im;
        end
    end

    // Exponent zero must reach the multiplier as unity: R5
    p_twid_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_k == '0) |=>
            (s1_w_re == TW'((2 ** (TW - 1)) - 1) && s1_w_im == '0));

endmodule

// File: rtl/bfly_cmul.sv
module bfly_cmul #(
    parameter int OW = 17,
    parameter int TW = 16,
    parameter int PW = OW + TW,
    parameter int MW = PW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 s1_valid,
    input  bfly_pkg::order_e     s1_order,
    input  logic                 s1_scale,
    input  logic signed [OW-1:0] s1_pass_re,
    input  logic signed [OW-1:0] s1_pass_im,
    input  logic signed [OW-1:0] s1_op_re,
    input  logic signed [OW-1:0] s1_op_im,
    input  logic signed [TW-1:0] s1_w_re,
    input  logic signed [TW-1:0] s1_w_im,
    output logic                 s2_valid,
    output bfly_pkg::order_e     s2_order,
    output logic                 s2_scale,
    output logic signed [OW-1:0] s2_pass_re,
    output logic signed [OW-1:0] s2_pass_im,
    output logic signed [MW-1:0] s2_prod_re,
    output logic signed [MW-1:0] s2_prod_im
);
    import bfly_pkg::*;

    logic signed [PW-1:0] p_rr, p_ii, p_ri, p_ir;
    logic signed [MW-1:0] nx_re, nx_im;

    // Four real products, two real adds: the only multiplier in the block
    always_comb begin
        p_rr  = PW'(s1_op_re) * PW'(s1_w_re);
        p_ii  = PW'(s1_op_im) * PW'(s1_w_im);
        p_ri  = PW'(s1_op_re) * PW'(s1_w_im);
        p_ir  = PW'(s1_op_im) * PW'(s1_w_re);
        nx_re = MW'(p_rr) - MW'(p_ii);
        nx_im = MW'(p_ri) + MW'(p_ir);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_valid   <= 1'b0;
            s2_order   <= ORDER_ROT_FIRST;
            s2_scale   <= 1'b0;
            s2_pass_re <= '0;
            s2_pass_im <= '0;
            s2_prod_re <= '0;
            s2_prod_im <= '0;
        end else begin
            s2_valid   <= s1_valid;
            s2_order   <= s1_order;
            s2_scale   <= s1_scale;
            s2_pass_re <= s1_pass_re;
            s2_pass_im <= s1_pass_im;
            s2_prod_re <= nx_re;
            s2_prod_im <= nx_im;
        end
    end

    // A zero operand rotates to zero regardless of twiddle: R3
    p_zero_rot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_op_re == '0 && s1_op_im == '0) |=>
            (s2_prod_re == '0 && s2_prod_im == '0));

    // Per-sample settings travel with the data: R8
    p_order_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |=> (s2_order == $past(s1_order) && s2_scale == $past(s1_scale)));

endmodule

// File: rtl/bfly_post.sv
module bfly_post #(
    parameter int DW = 16,
    parameter int TW = 16,
    parameter int OW = DW + 1,
    parameter int MW = OW + TW + 1,
    parameter int AW = MW + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 s2_valid,
    input  bfly_pkg::order_e     s2_order,
    input  logic                 s2_scale,
    input  logic signed [OW-1:0] s2_pass_re,
    input  logic signed [OW-1:0] s2_pass_im,
    input  logic signed [MW-1:0] s2_prod_re,
    input  logic signed [MW-1:0] s2_prod_im,
    output logic                 o_valid,
    output logic signed [DW-1:0] o_sum_re,
    output logic signed [DW-1:0] o_sum_im,
    output logic signed [DW-1:0] o_dif_re,
    output logic signed [DW-1:0] o_dif_im
);
    import bfly_pkg::*;

    localparam logic signed [AW-1:0] RND_HALF = AW'(2 ** (TW - 2));
    localparam logic signed [AW-1:0] MAXV     = AW'((2 ** (DW - 1)) - 1);
    localparam logic signed [AW-1:0] MINV     = AW'(-(2 ** (DW - 1)));
    localparam logic signed [AW-1:0] ONE      = AW'(1);

    function automatic logic signed [DW-1:0] finish(input logic signed [AW-1:0] v,
                                                    input logic sc);
        logic signed [AW-1:0] h;
        h = sc ? ((v + ONE) >>> 1) : v;
        if (h > MAXV)
            return DW'(MAXV);
        else if (h < MINV)
            return DW'(MINV);
        else
            return DW'(h);
    endfunction

    logic signed [AW-1:0] rot_re, rot_im, pw_re, pw_im;
    logic signed [AW-1:0] a_re, a_im, b_re, b_im;

    always_comb begin
        rot_re = (AW'(s2_prod_re) + RND_HALF) >>> (TW - 1);
        rot_im = (AW'(s2_prod_im) + RND_HALF) >>> (TW - 1);
        pw_re  = AW'(s2_pass_re);
        pw_im  = AW'(s2_pass_im);
        unique case (s2_order)
            ORDER_ROT_LAST: begin
                a_re = pw_re;
                a_im = pw_im;
                b_re = rot_re;
                b_im = rot_im;
            end
            default: begin
                a_re = pw_re + rot_re;
                a_im = pw_im + rot_im;
                b_re = pw_re - rot_re;
                b_im = pw_im - rot_im;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_valid  <= 1'b0;
            o_sum_re <= '0;
            o_sum_im <= '0;
            o_dif_re <= '0;
            o_dif_im <= '0;
        end else begin
            o_valid <= s2_valid;
            if (s2_valid) begin
                o_sum_re <= finish(a_re, s2_scale);
                o_sum_im <= finish(a_im, s2_scale);
                o_dif_re <= finish(b_re, s2_scale);
                o_dif_im <= finish(b_im, s2_scale);
            end
        end
    end

    // Words hold while no result is issued: R9
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !s2_valid |=> ($stable(o_sum_re) && $stable(o_sum_im) &&
                       $stable(o_dif_re) && $stable(o_dif_im)));

    // Frequency-decimated sum is never rotated, so positive overflow clamps: R7
    p_clamp_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_valid && !s2_scale && s2_order == ORDER_ROT_LAST && pw_re > MAXV) |=>
            (o_sum_re == DW'(MAXV)));

endmodule

// File: rtl/bfly_r2.sv
module bfly_r2 #(
    parameter int NPT = bfly_pkg::NPOINT_DEF,
    parameter int DW  = bfly_pkg::DATA_W_DEF,
    parameter int TW  = bfly_pkg::TWID_W_DEF,
    parameter int KW  = $clog2(NPT) - 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_order,
    input  logic                 in_scale,
    input  logic [KW-1:0]        in_k,
    input  logic signed [DW-1:0] in_x_re,
    input  logic signed [DW-1:0] in_x_im,
    input  logic signed [DW-1:0] in_y_re,
    input  logic signed [DW-1:0] in_y_im,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_sum_re,
    output logic signed [DW-1:0] out_sum_im,
    output logic signed [DW-1:0] out_dif_re,
    output logic signed [DW-1:0] out_dif_im
);
    import bfly_pkg::*;

    localparam int OW = DW + 1;
    localparam int MW = OW + TW + 1;

    logic signed [TW-1:0] w_re, w_im, s1_w_re, s1_w_im;
    logic                 s1_valid, s1_scale, s2_valid, s2_scale;
    order_e               s1_order, s2_order;
    logic signed [OW-1:0] s1_pass_re, s1_pass_im, s1_op_re, s1_op_im;
    logic signed [OW-1:0] s2_pass_re, s2_pass_im;
    logic signed [MW-1:0] s2_prod_re, s2_prod_im;

    bfly_twiddle_rom #(.NPT(NPT), .TW(TW), .KW(KW)) i_rom (
        .k    (in_k),
        .w_re (w_re),
        .w_im (w_im)
    );

    bfly_pre #(.DW(DW), .TW(TW), .KW(KW), .OW(OW)) i_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_order   (in_order),
        .in_scale   (in_scale),
        .in_k       (in_k),
        .x_re       (in_x_re),
        .x_im       (in_x_im),
        .y_re       (in_y_re),
        .y_im       (in_y_im),
        .w_re       (w_re),
        .w_im       (w_im),
        .s1_valid   (s1_valid),
        .s1_order   (s1_order),
        .s1_scale   (s1_scale),
        .s1_pass_re (s1_pass_re),
        .s1_pass_im (s1_pass_im),
        .s1_op_re   (s1_op_re),
        .s1_op_im   (s1_op_im),
        .s1_w_re    (s1_w_re),
        .s1_w_im    (s1_w_im)
    );

    bfly_cmul #(.OW(OW), .TW(TW), .PW(OW + TW), .MW(MW)) i_cmul (
        .clk        (clk),
        .rst_n      (rst_n),
        .s1_valid   (s1_valid),
        .s1_order   (s1_order),
        .s1_scale   (s1_scale),
        .s1_pass_re (s1_pass_re),
        .s1_pass_im (s1_pass_im),
        .s1_op_re   (s1_op_re),
        .s1_op_im   (s1_op_im),
        .s1_w_re    (s1_w_re),
        .s1_w_im    (s1_w_im),
        .s2_valid   (s2_valid),
        .s2_order   (s2_order),
        .s2_scale   (s2_scale),
        .s2_pass_re (s2_pass_re),
        .s2_pass_im (s2_pass_im),
        .s2_prod_re (s2_prod_re),
        .s2_prod_im (s2_prod_im)
    );

    bfly_post #(.DW(DW), .TW(TW), .OW(OW), .MW(MW), .AW(MW + 2)) i_post (
        .clk        (clk),
        .rst_n      (rst_n),
        .s2_valid   (s2_valid),
        .s2_order   (s2_order),
        .s2_scale   (s2_scale),
        .s2_pass_re (s2_pass_re),
        .s2_pass_im (s2_pass_im),
        .s2_prod_re (s2_prod_re),
        .s2_prod_im (s2_prod_im),
        .o_valid    (out_valid),
        .o_sum_re   (out_sum_re),
        .o_sum_im   (out_sum_im),
        .o_dif_re   (out_dif_re),
        .o_dif_im   (out_dif_im)
    );

    // Fixed three-cycle latency in both orders: R2
    p_latency_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##3 out_valid);

    p_latency_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##3 !out_valid);

    // All-zero samples give all-zero results whatever the settings: R6
    p_zero_in_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_x_re == '0 && in_x_im == '0 && in_y_re == '0 && in_y_im == '0)
            |-> ##3 (out_sum_re == '0 && out_sum_im == '0 &&
                     out_dif_re == '0 && out_dif_im == '0));

endmodule

// File: tb/test_bfly_r2.sv
module test_bfly_r2;

    localparam int NPT = 64;
    localparam int KW  = 5;
    localparam real PI = 3.14159265358979323846;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_order = 1'b0, in_scale = 1'b0;
    logic [KW-1:0] in_k = '0;
    logic signed [15:0] in_x_re = '0, in_x_im = '0, in_y_re = '0, in_y_im = '0;
    logic out_valid;
    logic signed [15:0] out_sum_re, out_sum_im, out_dif_re, out_dif_im;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    bit    qv[$];
    int    qsr[$], qsi[$], qdr[$], qdi[$];
    string qtag[$];
    int last_sr = 0, last_si = 0, last_dr = 0, last_di = 0;

    always #4 clk = ~clk;

    bfly_r2 #(.NPT(NPT)) i_bfly_r2 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_order(in_order),
        .in_scale(in_scale), .in_k(in_k),
        .in_x_re(in_x_re), .in_x_im(in_x_im), .in_y_re(in_y_re), .in_y_im(in_y_im),
        .out_valid(out_valid), .out_sum_re(out_sum_re), .out_sum_im(out_sum_im),
        .out_dif_re(out_dif_re), .out_dif_im(out_dif_im)
    );

    function automatic int qr(input real v);
        if (v >= 0.0) return $rtoi(v + 0.5);
        else return $rtoi(v - 0.5);
    endfunction

    function automatic longint tw_re(input int k);
        return longint'(qr($cos(2.0 * PI * k / NPT) * 32767.0));
    endfunction

    function automatic longint tw_im(input int k);
        return longint'(qr(-$sin(2.0 * PI * k / NPT) * 32767.0));
    endfunction

    function automatic longint rnd15(input longint p);
        return (p + 64'sd16384) >>> 15;
    endfunction

    function automatic int fin(input longint v, input bit sc);
        longint h;
        h = sc ? ((v + 1) >>> 1) : v;
        if (h > 32767) return 32767;
        if (h < -32768) return -32768;
        return int'(h);
    endfunction

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_out();
        bit v; int sr, si, dr, di; string tag;
        if (qv.size() < 3) return;
        v = qv.pop_front(); sr = qsr.pop_front(); si = qsi.pop_front();
        dr = qdr.pop_front(); di = qdi.pop_front(); tag = qtag.pop_front();
        cmp("R2", "out_valid", int'(out_valid), int'(v));
        if (v) begin
            cmp(tag, "sum_re", int'(out_sum_re), sr);
            cmp(tag, "sum_im", int'(out_sum_im), si);
            cmp(tag, "dif_re", int'(out_dif_re), dr);
            cmp(tag, "dif_im", int'(out_dif_im), di);
            last_sr = sr; last_si = si; last_dr = dr; last_di = di;
        end else begin
            cmp("R9", "hold sum_re", int'(out_sum_re), last_sr);
            cmp("R9", "hold sum_im", int'(out_sum_im), last_si);
            cmp("R9", "hold dif_re", int'(out_dif_re), last_dr);
            cmp("R9", "hold dif_im", int'(out_dif_im), last_di);
        end
    endtask

    task automatic step(input bit v, input bit ord, input bit sc, input int k,
                        input int xr, input int xi, input int yr, input int yi,
                        input string tag);
        longint wr, wi, a, b, tr, ti;
        @(negedge clk);
        check_out();
        in_valid = v; in_order = ord; in_scale = sc; in_k = KW'(k);
        in_x_re = 16'(xr); in_x_im = 16'(xi); in_y_re = 16'(yr); in_y_im = 16'(yi);
        wr = tw_re(k); wi = tw_im(k);
        qv.push_back(v); qtag.push_back(tag);
        if (!ord) begin
            tr = rnd15(longint'(yr) * wr - longint'(yi) * wi);
            ti = rnd15(longint'(yr) * wi + longint'(yi) * wr);
            qsr.push_back(fin(xr + tr, sc)); qsi.push_back(fin(xi + ti, sc));
            qdr.push_back(fin(xr - tr, sc)); qdi.push_back(fin(xi - ti, sc));
        end else begin
            a = longint'(xr) - yr; b = longint'(xi) - yi;
            qsr.push_back(fin(longint'(xr) + yr, sc)); qsi.push_back(fin(longint'(xi) + yi, sc));
            qdr.push_back(fin(rnd15(a * wr - b * wi), sc));
            qdi.push_back(fin(rnd15(a * wi + b * wr), sc));
        end
    endtask

    function automatic int rs(input int lim);
        return $urandom_range(0, 2 * lim) - lim;
    endfunction

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(17));
        repeat (3) @(negedge clk);
        // R1: reset state
        cmp("R1", "out_valid", int'(out_valid), 0);
        cmp("R1", "sum_re", int'(out_sum_re), 0);
        cmp("R1", "sum_im", int'(out_sum_im), 0);
        cmp("R1", "dif_re", int'(out_dif_re), 0);
        cmp("R1", "dif_im", int'(out_dif_im), 0);
        rst_n = 1'b1;
        repeat (3) begin
            qv.push_back(0); qsr.push_back(0); qsi.push_back(0);
            qdr.push_back(0); qdi.push_back(0); qtag.push_back("R1");
        end
        // R5: sweep every table entry, sum = W*y with x = 0
        for (int k = 0; k < NPT / 2; k++) step(1, 0, 0, k, 0, 0, 20000, 0, "R5");
        for (int k = 0; k < NPT / 2; k++) step(1, 1, 0, k, 0, 0, 0, -20000, "R5");
        // R3: time-decimated order
        for (int i = 0; i < 40; i++)
            step(1, 0, 0, $urandom_range(0, 31), rs(12000), rs(12000), rs(12000), rs(12000), "R3");
        // R4: frequency-decimated order
        for (int i = 0; i < 40; i++)
            step(1, 1, 0, $urandom_range(0, 31), rs(12000), rs(12000), rs(12000), rs(12000), "R4");
        // R8: settings change every cycle
        for (int i = 0; i < 30; i++)
            step(1, i[0], i[1], $urandom_range(0, 31), rs(15000), rs(15000), rs(15000), rs(15000), "R8");
        // R2/R9: valid gaps
        for (int i = 0; i < 30; i++)
            step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 0, $urandom_range(0, 31),
                 rs(10000), rs(10000), rs(10000), rs(10000), "R2");
        // R6: halving with rounding, directed then full range
        step(1, 1, 1, 0, 3, -3, 0, 0, "R6");
        step(1, 1, 1, 0, 1, -1, 0, 0, "R6");
        for (int i = 0; i < 20; i++)
            step(1, 1'($urandom_range(0, 1)), 1, $urandom_range(0, 31),
                 rs(32767), rs(32767), rs(32767), rs(32767), "R6");
        // R7: saturation at both rails
        step(1, 0, 0, 0, 32767, 32767, 32767, 32767, "R7");
        step(1, 0, 0, 0, -32768, -32768, 32767, 32767, "R7");
        step(1, 1, 0, 0, 32767, -32768, -32768, 32767, "R7");
        step(1, 1, 0, 16, 32767, 32767, 32767, 32767, "R7");
        for (int i = 0; i < 20; i++)
            step(1, 1'($urandom_range(0, 1)), 0, $urandom_range(0, 31),
                 rs(32767), rs(32767), rs(32767), rs(32767), "R7");
        // flush, then idle hold (R9)
        for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, 0, 0, 0, "R9");
        @(negedge clk);
        check_out();
        done = 1;
        summary();
        $finish;
    end

endmodule